// File: doc/BRIEF.md
# Stream ID Packet Router

This block is a one-input, six-output packet switch for 64-bit AXI4-Stream traffic. It looks at the first beat of each packet and matches the 16-bit stream identifier in that beat's low bits against a small table of match values. It then sends the whole packet, unchanged, to the output channel whose table entry matched. The table has one entry per output channel. Software fills it through one configuration register address. Each write to that address names an entry and the value it should match.

The decision is made on the header beat and is held until the beat that carries tlast. Later beats of the same packet are never decoded again, and table writes made during a packet do not affect it. A packet whose identifier matches no entry is consumed and discarded. The block passes data through with no registers on the data path, so it adds no latency. Buffering, padding and clock crossing are left to neighbouring blocks.

Top module: `sid_router`

## Requirements
- R1: After reset no output asserts tvalid while the input is idle, and table entry n holds the match value n, so an unprogrammed block sends ID n to channel n.
- R2: A write to the configuration address `TBL_ADDR` (default 0x500) sets one entry. Bits [15:0] of the written word select the entry (which is also the output channel) and bits [31:16] give its match value. Writes to any other address, or with an entry number of `NUM_CH` or more, change nothing.
- R3: A later write to an entry replaces its earlier match value, so the old value no longer routes to that channel.
- R4: The match key is bits [15:0] of a packet's first beat. A packet whose key equals entry n leaves on channel n only, with every beat's tdata and tlast passed unchanged and in the same cycle.
- R5: The channel chosen on the header beat is used for every beat up to and including tlast. This holds even when later beats carry a different value in bits [15:0], and even when the table is rewritten mid-packet.
- R6: A packet whose key matches no entry is dropped: input tready stays high and no output asserts tvalid until its tlast beat has been accepted.
- R7: When several entries hold the key, the lowest-numbered one wins.
- R8: For a routed packet, input tready equals the tready of the chosen output, and at most one output tvalid is high at any time.
- R9: The beat after an accepted tlast is treated as a new header and gets a fresh routing decision from the current table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_ADDR_W (20) | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data: match value in [31:16], entry in [15:0] |
| s_tdata | input | DATA_W (64) | Input stream data |
| s_tvalid | input | 1 | Input stream valid |
| s_tlast | input | 1 | Input stream last beat |
| s_tready | output | 1 | Input stream ready |
| m_tdata | output | NUM_CH*DATA_W (384) | Output data, channel n in lane n |
| m_tvalid | output | NUM_CH (6) | Output valid, one bit per channel |
| m_tlast | output | NUM_CH (6) | Output last, one bit per channel |
| m_tready | input | NUM_CH (6) | Output ready, one bit per channel |

## Verification
Single-beat packets are swept across every programmed key, a key whose entry was overwritten, a key that was written only to an out-of-range entry or a wrong address, and a key held by two entries. Together these separate a correct match from stale table contents, from ignored writes and from the wrong priority. Multi-beat packets whose later beats carry other keys, with a table write in the middle, show whether the decision is really held. Packets that are dropped while every output refuses, and routed packets that face selective backpressure, separate the drop path from ready steering. A packet right after a tlast confirms that the decision is made afresh.

// File: rtl/sid_route_pkg.sv
package sid_route_pkg;
   localparam int ID_W  = 16;
   localparam int CFG_W = 32;

   typedef struct packed {
      logic [ID_W-1:0] id;
      logic [15:0]     entry;
   } cfg_word_t;
endpackage

// File: rtl/sid_route_table.sv
module sid_route_table
   import sid_route_pkg::*;
#(
   parameter int NUM_CH     = 6,
   parameter int CFG_ADDR_W = 20,
   parameter logic [CFG_ADDR_W-1:0] TBL_ADDR = 20'h00500,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  cfg_wr,
   input  logic [CFG_ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]      cfg_wdata,
   input  logic [ID_W-1:0]       key,
   output logic [NUM_CH-1:0]     hit
);
   cfg_word_t cw;
   logic      wr_ok;
   logic [ID_W-1:0] tbl [NUM_CH];

   assign cw    = cfg_word_t'(cfg_wdata);
   assign wr_ok = cfg_wr && (cfg_addr == TBL_ADDR) && (cw.entry < 16'(NUM_CH));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (rst)
            tbl[g] <= ID_W'(g);
         else if (wr_ok && (cw.entry[CH_W-1:0] == CH_W'(g)))
            tbl[g] <= cw.id;
      end
      assign hit[g] = (tbl[g] == key);
   end
endmodule

// File: rtl/sid_route_prio.sv
module sid_route_prio #(
   parameter int N = 6,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = W'(i);
         end
      end
   end
endmodule

// File: rtl/sid_route_steer.sv
module sid_route_steer #(
   parameter int NUM_CH = 6,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hit_any,
   input  logic [CH_W-1:0]   hit_idx,
   input  logic              s_tvalid,
   input  logic              s_tlast,
   output logic              s_tready,
   output logic [NUM_CH-1:0] m_tvalid,
   input  logic [NUM_CH-1:0] m_tready,
   output logic              pkt_open,
   output logic              pkt_drop,
   output logic [CH_W-1:0]   pkt_chan
);
   logic [CH_W-1:0]   cur_sel;
   logic              cur_drop;
   logic [NUM_CH-1:0] sel_oh;
   logic              xfer;

   assign cur_sel  = pkt_open ? pkt_chan : hit_idx;
   assign cur_drop = pkt_open ? pkt_drop : !hit_any;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
      assign sel_oh[g]   = (cur_sel == CH_W'(g));
      assign m_tvalid[g] = s_tvalid && !cur_drop && sel_oh[g];
   end

   assign s_tready = cur_drop || (|(sel_oh & m_tready));
   assign xfer     = s_tvalid && s_tready;

   always_ff @(posedge clk) begin
      if (rst) begin
         pkt_open <= 1'b0;
         pkt_drop <= 1'b0;
         pkt_chan <= '0;
      end else if (xfer) begin
         pkt_open <= !s_tlast;
         pkt_drop <= cur_drop;
         pkt_chan <= cur_sel;
      end
   end
endmodule

// File: rtl/sid_router.sv
module sid_router
   import sid_route_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int NUM_CH     = 6,
   parameter int CFG_ADDR_W = 20,
   parameter logic [CFG_ADDR_W-1:0] TBL_ADDR = 20'h00500
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     cfg_wr,
   input  logic [CFG_ADDR_W-1:0]    cfg_addr,
   input  logic [31:0]              cfg_wdata,
   input  logic [DATA_W-1:0]        s_tdata,
   input  logic                     s_tvalid,
   input  logic                     s_tlast,
   output logic                     s_tready,
   output logic [NUM_CH*DATA_W-1:0] m_tdata,
   output logic [NUM_CH-1:0]        m_tvalid,
   output logic [NUM_CH-1:0]        m_tlast,
   input  logic [NUM_CH-1:0]        m_tready
);
   localparam int CH_W = $clog2(NUM_CH);

   if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_ch
      $error("sid_router: NUM_CH must lie in 2..64");
   end
   if (DATA_W < ID_W) begin : g_bad_w
      $error("sid_router: DATA_W narrower than the ID field");
   end

   logic [NUM_CH-1:0] hit;
   logic              hit_any;
   logic [CH_W-1:0]   hit_idx;
   logic              pkt_open, pkt_drop;
   logic [CH_W-1:0]   pkt_chan;

   sid_route_table #(
      .NUM_CH(NUM_CH), .CFG_ADDR_W(CFG_ADDR_W), .TBL_ADDR(TBL_ADDR)
   ) u_tbl (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .key(s_tdata[ID_W-1:0]), .hit(hit)
   );

   sid_route_prio #(.N(NUM_CH)) u_prio (
      .req(hit), .any(hit_any), .idx(hit_idx)
   );

   sid_route_steer #(.NUM_CH(NUM_CH)) u_steer (
      .clk(clk), .rst(rst), .hit_any(hit_any), .hit_idx(hit_idx),
      .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
      .m_tvalid(m_tvalid), .m_tready(m_tready),
      .pkt_open(pkt_open), .pkt_drop(pkt_drop), .pkt_chan(pkt_chan)
   );

   assign m_tdata = {NUM_CH{s_tdata}};
   assign m_tlast = {NUM_CH{s_tlast}};
endmodule

// File: rtl/sid_router_chk.sv
module sid_router_chk #(
   parameter int NUM_CH = 6,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input logic              clk,
   input logic              rst,
   input logic              s_tvalid,
   input logic              s_tready,
   input logic              s_tlast,
   input logic [NUM_CH-1:0] m_tvalid,
   input logic [NUM_CH-1:0] m_tready,
   input logic              pkt_open,
   input logic              pkt_drop,
   input logic [CH_W-1:0]   pkt_chan
);
   a_r4_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
      (|m_tvalid) |-> s_tvalid);

   a_r5_held_lane: assert property (@(posedge clk) disable iff (rst)
      (pkt_open && !pkt_drop && s_tvalid) |-> (m_tvalid == (NUM_CH'(1) << pkt_chan)));

   a_r5_chan_stable: assert property (@(posedge clk) disable iff (rst)
      (pkt_open && $past(pkt_open) && !$past(rst)) |-> $stable(pkt_chan));

   a_r6_drop_sink: assert property (@(posedge clk) disable iff (rst)
      (pkt_open && pkt_drop) |-> (s_tready && (m_tvalid == '0)));

   a_r8_one_lane: assert property (@(posedge clk) disable iff (rst)
      $onehot0(m_tvalid));

   a_r8_ready_follow: assert property (@(posedge clk) disable iff (rst)
      (|m_tvalid) |-> (s_tready == (|(m_tvalid & m_tready))));

   a_r9_close: assert property (@(posedge clk) disable iff (rst)
      (s_tvalid && s_tready && s_tlast) |=> !pkt_open);
endmodule

bind sid_router sid_router_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst(rst), .s_tvalid(s_tvalid), .s_tready(s_tready),
   .s_tlast(s_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
   .pkt_open(pkt_open), .pkt_drop(pkt_drop), .pkt_chan(pkt_chan)
);

// File: tb/sid_router_tb_top.sv
`timescale 1ns/1ps
module sid_router_tb_top;
   localparam int NCH = 6;
   localparam int DW  = 64;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cfg_wr = 1'b0;
   logic [19:0]       cfg_addr = '0;
   logic [31:0]       cfg_wdata = '0;
   logic [DW-1:0]     s_tdata = '0;
   logic              s_tvalid = 1'b0;
   logic              s_tlast = 1'b0;
   logic              s_tready;
   logic [NCH*DW-1:0] m_tdata;
   logic [NCH-1:0]    m_tvalid;
   logic [NCH-1:0]    m_tlast;
   logic [NCH-1:0]    m_tready = '1;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   sid_router dut_i (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
      .s_tlast(s_tlast), .s_tready(s_tready), .m_tdata(m_tdata),
      .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready)
   );

   // {drop, channel, key}
   localparam logic [19:0] VEC [10] = '{
      {1'b0, 3'd1, 16'h00D2},
      {1'b0, 3'd0, 16'h00D3},
      {1'b0, 3'd2, 16'h0002},
      {1'b0, 3'd3, 16'h0003},
      {1'b0, 3'd4, 16'h0004},
      {1'b1, 3'd0, 16'h0001},
      {1'b1, 3'd0, 16'h0000},
      {1'b1, 3'd0, 16'h0077},
      {1'b1, 3'd0, 16'h0055},
      {1'b1, 3'd0, 16'h0005}
   };

   task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [19:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // drive one beat at a negedge; checks follow 1 ns later
   task automatic drive(input logic [63:0] d, input logic last);
      @(negedge clk);
      s_tdata = d; s_tvalid = 1'b1; s_tlast = last;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      s_tvalid = 1'b0; s_tlast = 1'b0;
   endtask

   function automatic logic [NCH-1:0] oh(input int c);
      return NCH'(1) << c;
   endfunction

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] w;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      chk(m_tvalid == '0, "R1 idle valid", 64'(m_tvalid), 64'd0);
      drive(64'h1111_0010_0000_0005, 1'b1);
      chk(m_tvalid == oh(5), "R1 default entry5", 64'(m_tvalid), 64'(oh(5)));
      drive(64'h2222_0010_0000_0000, 1'b1);
      chk(m_tvalid == oh(0), "R1 default entry0", 64'(m_tvalid), 64'(oh(0)));
      idle();

      // program table: R2, R3, R7
      cfg(20'h00500, 32'h0001_0001);
      cfg(20'h00500, 32'h00D2_0001);  // R3 overwrite
      cfg(20'h00500, 32'h00D3_0000);
      cfg(20'h00500, 32'h0003_0005);  // R7 duplicate of entry 3
      cfg(20'h00500, 32'h0077_0009);  // R2 entry out of range
      cfg(20'h00504, 32'h0055_0002);  // R2 wrong address

      // table walk (R2 R3 R4 R7)
      for (int i = 0; i < 10; i++) begin
         w = {8'hC0 + 8'(i), 24'h00_0040, 16'h0000, VEC[i][15:0]};
         drive(w, 1'b1);
         if (VEC[i][19]) begin
            chk(m_tvalid == '0 && s_tready, "R2/R3 unmatched key dropped", 64'(m_tvalid), 64'd0);
         end else begin
            chk(m_tvalid == oh(int'(VEC[i][18:16])), "R4/R7 lane select",
                64'(m_tvalid), 64'(oh(int'(VEC[i][18:16]))));
            chk(m_tdata[int'(VEC[i][18:16])*DW +: DW] == w && m_tlast[VEC[i][18:16]],
                "R4 data and last passthrough", m_tdata[int'(VEC[i][18:16])*DW +: DW], w);
         end
      end
      idle();

      // R5: hold decision across beats and a mid-packet table write
      drive(64'h0000_0018_0000_00D2, 1'b0);
      chk(m_tvalid == oh(1), "R5 header to ch1", 64'(m_tvalid), 64'(oh(1)));
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 20'h00500; cfg_wdata = 32'h0099_0001;
      s_tdata = 64'h0000_0000_0000_00D3; s_tlast = 1'b0;
      #1;
      chk(m_tvalid == oh(1), "R5 body beat held", 64'(m_tvalid), 64'(oh(1)));
      @(negedge clk);
      cfg_wr = 1'b0;
      s_tdata = 64'h0000_0000_0000_0004; s_tlast = 1'b1;
      #1;
      chk(m_tvalid == oh(1) && m_tlast[1], "R5 last beat held", 64'(m_tvalid), 64'(oh(1)));
      // R9: fresh decision from rewritten table
      drive(64'h0000_0008_0000_00D2, 1'b1);
      chk(m_tvalid == '0, "R9 new header uses new table", 64'(m_tvalid), 64'd0);
      drive(64'h0000_0008_0000_0099, 1'b1);
      chk(m_tvalid == oh(1), "R9 new key routes", 64'(m_tvalid), 64'(oh(1)));
      idle();

      // R6: dropped packet sinks even with all outputs stalled
      m_tready = '0;
      drive(64'h0000_0018_0000_0123, 1'b0);
      chk(s_tready && m_tvalid == '0, "R6 drop header", {s_tready, 7'(m_tvalid)}, 64'h80);
      drive(64'h0000_0000_0000_0099, 1'b0);
      chk(s_tready && m_tvalid == '0, "R6 drop body matching key", {s_tready, 7'(m_tvalid)}, 64'h80);
      drive(64'h0000_0000_0000_0002, 1'b1);
      chk(s_tready && m_tvalid == '0, "R6 drop last", {s_tready, 7'(m_tvalid)}, 64'h80);

      // R8: ready follows selected output
      drive(64'h0000_0010_0000_0002, 1'b0);
      chk(!s_tready && m_tvalid == oh(2), "R8 stalled header", {s_tready, 7'(m_tvalid)}, 64'(oh(2)));
      m_tready = 6'b111011;
      #1;
      chk(!s_tready, "R8 other readies ignored", 64'(s_tready), 64'd0);
      m_tready = 6'b000100;
      #1;
      chk(s_tready, "R8 selected ready passes", 64'(s_tready), 64'd1);
      drive(64'h0000_0000_0000_00D3, 1'b1);
      m_tready = 6'b000001;
      #1;
      chk(!s_tready && m_tvalid == oh(2), "R8 R5 body stall on ch2", {s_tready, 7'(m_tvalid)}, 64'(oh(2)));
      m_tready = '1;
      #1;
      chk(s_tready, "R8 body released", 64'(s_tready), 64'd1);
      idle();
      #1;
      chk(m_tvalid == '0, "R4 idle after packets", 64'(m_tvalid), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule